// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This block sits between a simple memory-mapped host port and a raw 8-bit NAND flash bus. Software drives the flash one byte at a time. It sets the command-latch, address-latch and chip-enable lines through a mode register. Each access to the data register then becomes one timed write or read strobe on the flash bus. The strobe pulse width and the data hold time are programmable in bus clocks through a timing register. The flash ready/busy line is synchronised and shown as a status bit. Its busy-to-ready transition is latched as a maskable interrupt. A self-clearing soft reset returns every register to its default state.

Each host access completes in the cycle where `h_sel` and `h_ready` are both high. A write to the data register is accepted at once, and the strobe and hold run after it. Any access that arrives while a strobe or its hold is in progress is stalled. A read of the data register is stalled until the byte has been sampled from the flash.

Top module: `nfbus_ctrl`

## Requirements
- R1: After reset, every chip enable is high, both strobes are high, CLE, ALE and the bus drive enable are low, and `h_ready` is high.
- R2: Mode register (offset 0x04) field map:
   - bit 0 drives CLE and bit 1 drives ALE.
   - bits 3:2 pick the chip-enable output; that output alone goes low while bit 4 is 1, and all outputs are high while bit 4 is 0.
   - bit 7 is the data write enable.
   - bits 6:5 read as 0.
- R3: A data-register write (offset 0x00) made while CLE, ALE or the data write enable is set drives the low 8 bits of the write data on the bus. It drives the write strobe low for SPW+1 clocks, starting the cycle after acceptance.
- R4: A data-register write made with CLE, ALE and the data write enable all clear produces no strobe and does not stall the host.
- R5: After each write strobe the bus stays driven for max(HOLD,1) clocks. No further access is accepted until the strobe and hold are over, so the controller is busy for SPW+1+max(HOLD,1) cycles.
- R6: A data-register read drives the read strobe low for SPW+1 clocks. It returns, in the following cycle, the byte present on the bus at the clock edge that ends the strobe.
- R7: Status register (offset 0x08) bit 7 reads 1 while the synchronised ready/busy input is low.
- R8: Interrupt status (offset 0x0C) bit 0 is set on each busy-to-ready transition and is cleared by writing 1. `irq` is high while that bit and interrupt mask (offset 0x10) bit 0 are both 1.
- R9: Writing 1 to reset register (offset 0x18) bit 0 makes the bit read 1 for RST_CYCLES clocks, then 0. Mode, timing, mask and interrupt status return to their defaults.
- R10: Timing register (offset 0x14) holds HOLD in bits 7:4 and SPW in bits 3:0 and reads back as written. Its default is HOLD=1, SPW=3 (0x13).
- R11: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host access request |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | AW | Byte offset of the register |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, valid while h_ready is high |
| h_ready | output | 1 | Access completes on this cycle |
| irq | output | 1 | Masked ready interrupt |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_ce_n | output | NCS | Active-low chip enables |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_re_n | output | 1 | Active-low read strobe |
| fl_dq_o | output | 8 | Byte driven to the flash |
| fl_dq_oe | output | 1 | Bus drive enable |
| fl_dq_in | input | 8 | Byte from the flash |
| fl_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The properties assume that the host holds `h_sel`, `h_wr`, `h_addr` and `h_wdata` unchanged from request until `h_ready` is seen high. They also assume that a stalled data read is never withdrawn. The bench driver changes inputs only on falling edges and releases the request right after the completing rising edge. `fl_rb_n` is treated as asynchronous, so the bench toggles it freely and waits out the synchroniser before it reads the status. The flash model changes `fl_dq_in` only while the read strobe is low, so the bus carries a distinct value at each cycle of the strobe.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

   localparam logic [7:0] OFS_DATA  = 8'h00;
   localparam logic [7:0] OFS_MODE  = 8'h04;
   localparam logic [7:0] OFS_STAT  = 8'h08;
   localparam logic [7:0] OFS_ISR   = 8'h0C;
   localparam logic [7:0] OFS_IMR   = 8'h10;
   localparam logic [7:0] OFS_TIME  = 8'h14;
   localparam logic [7:0] OFS_SRST  = 8'h18;

   localparam logic [7:0] MODE_WMASK = 8'h9F;

   typedef struct packed {
      logic       wen;
      logic [1:0] rsv;
      logic       ce;
      logic [1:0] cs;
      logic       ale;
      logic       cle;
   } mode_t;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_WSTB,
      SQ_HOLD,
      SQ_RSTB,
      SQ_RDONE
   } seq_state_t;

endpackage

// File: rtl/nfc_sync.sv
module nfc_sync #(
   parameter int    STAGES  = 2,
   parameter logic  RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nfc_strobe_seq.sv
module nfc_strobe_seq
   import nfc_pkg::*;
#(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          start_wr,
   input  logic          start_rd,
   input  logic [7:0]    wbyte,
   input  logic [TW-1:0] spw,
   input  logic [TW-1:0] hold,
   input  logic [7:0]    dq_in,
   output logic          we_n,
   output logic          re_n,
   output logic [7:0]    dq_o,
   output logic          dq_oe,
   output logic          idle,
   output logic          rdone,
   output logic [7:0]    rbyte
);
   seq_state_t    state_q;
   logic [TW-1:0] cnt_q;
   logic [TW-1:0] hold_last;
   logic          strobe_end;

   // a hold code of zero still gives one cycle of hold
   assign hold_last  = (hold == '0) ? '0 : hold - 1'b1;
   assign strobe_end = (cnt_q == spw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         dq_o    <= '0;
         rbyte   <= '0;
      end else if (clr) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         dq_o    <= '0;
         rbyte   <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               cnt_q <= '0;
               if (start_wr) begin
                  state_q <= SQ_WSTB;
                  dq_o    <= wbyte;
               end else if (start_rd) begin
                  state_q <= SQ_RSTB;
               end
            end
            SQ_WSTB: begin
               if (strobe_end) begin
                  state_q <= SQ_HOLD;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_HOLD: begin
               if (cnt_q == hold_last) begin
                  state_q <= SQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_RSTB: begin
               if (strobe_end) begin
                  state_q <= SQ_RDONE;
                  rbyte   <= dq_in;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_RDONE: state_q <= SQ_IDLE;
            default:  state_q <= SQ_IDLE;
         endcase
      end
   end

   assign we_n  = (state_q != SQ_WSTB);
   assign re_n  = (state_q != SQ_RSTB);
   assign dq_oe = (state_q == SQ_WSTB) || (state_q == SQ_HOLD);
   assign idle  = (state_q == SQ_IDLE);
   assign rdone = (state_q == SQ_RDONE);
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
   import nfc_pkg::*;
#(
   parameter int         DW         = 32,
   parameter int         RST_CYCLES = 8,
   parameter logic [3:0] DEF_HOLD   = 4'd1,
   parameter logic [3:0] DEF_SPW    = 4'd3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    ofs,
   input  logic [7:0]    wbyte,
   input  logic          busy,
   input  logic          ready_rise,
   output mode_t         mode,
   output logic [3:0]    spw,
   output logic [3:0]    hold,
   output logic          srst_active,
   output logic          irq,
   output logic [DW-1:0] rd_data
);
   localparam int RCW = $clog2(RST_CYCLES + 1);
   localparam logic [RCW-1:0] RST_LOAD = RCW'(RST_CYCLES);
   localparam logic [7:0] DEF_TIME = {DEF_HOLD, DEF_SPW};

   logic [7:0]     mode_q;
   logic [7:0]     time_q;
   logic           imr_q;
   logic           isr_q;
   logic [RCW-1:0] rcnt_q;

   assign srst_active = (rcnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt_q <= '0;
      end else if (wr_en && ofs == OFS_SRST && wbyte[0]) begin
         rcnt_q <= RST_LOAD;
      end else if (srst_active) begin
         rcnt_q <= rcnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         time_q <= DEF_TIME;
         imr_q  <= 1'b0;
         isr_q  <= 1'b0;
      end else if (srst_active) begin
         mode_q <= '0;
         time_q <= DEF_TIME;
         imr_q  <= 1'b0;
         isr_q  <= 1'b0;
      end else begin
         if (wr_en && ofs == OFS_MODE) mode_q <= wbyte & MODE_WMASK;
         if (wr_en && ofs == OFS_TIME) time_q <= wbyte;
         if (wr_en && ofs == OFS_IMR)  imr_q  <= wbyte[0];
         // a new ready edge wins over a clear in the same cycle
         if (ready_rise)
            isr_q <= 1'b1;
         else if (wr_en && ofs == OFS_ISR && wbyte[0])
            isr_q <= 1'b0;
      end
   end

   assign mode = mode_t'(mode_q);
   assign spw  = time_q[3:0];
   assign hold = time_q[7:4];
   assign irq  = isr_q & imr_q;

   always_comb begin
      rd_data = '0;
      unique case (ofs)
         OFS_MODE: rd_data[7:0] = mode_q;
         OFS_STAT: rd_data[7]   = busy;
         OFS_ISR:  rd_data[0]   = isr_q;
         OFS_IMR:  rd_data[0]   = imr_q;
         OFS_TIME: rd_data[7:0] = time_q;
         OFS_SRST: rd_data[0]   = srst_active;
         default:  rd_data      = '0;
      endcase
   end
endmodule

// File: rtl/nfbus_ctrl.sv
module nfbus_ctrl
   import nfc_pkg::*;
#(
   parameter int         AW          = 5,
   parameter int         DW          = 32,
   parameter int         NCS         = 4,
   parameter int         SYNC_STAGES = 2,
   parameter int         RST_CYCLES  = 8,
   parameter logic [3:0] DEF_HOLD    = 4'd1,
   parameter logic [3:0] DEF_SPW     = 4'd3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           h_sel,
   input  logic           h_wr,
   input  logic [AW-1:0]  h_addr,
   input  logic [DW-1:0]  h_wdata,
   output logic [DW-1:0]  h_rdata,
   output logic           h_ready,
   output logic           irq,
   output logic           fl_cle,
   output logic           fl_ale,
   output logic [NCS-1:0] fl_ce_n,
   output logic           fl_we_n,
   output logic           fl_re_n,
   output logic [7:0]     fl_dq_o,
   output logic           fl_dq_oe,
   input  logic [7:0]     fl_dq_in,
   input  logic           fl_rb_n
);
   generate
      if (NCS < 1 || NCS > 4) begin : g_bad_ncs
         $error("NCS must be 1..4");
      end
      if (AW < 5 || AW > 8) begin : g_bad_aw
         $error("AW must be 5..8");
      end
      if (DW < 8) begin : g_bad_dw
         $error("DW must be at least 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [7:0]    ofs;
   logic          is_data;
   logic          data_rd;
   logic          accept;
   logic          start_wr;
   logic          start_rd;
   logic          reg_wr;
   logic          seq_idle;
   logic          seq_rdone;
   logic [7:0]    rbyte;
   logic          srst_active;
   logic          rb_s;
   logic          rb_prev_q;
   mode_t         mode;
   logic [3:0]    spw;
   logic [3:0]    hold;
   logic [DW-1:0] reg_rdata;
   logic          unused_bits;

   assign unused_bits = ^h_wdata | ^mode.rsv;

   always_comb begin
      ofs = '0;
      ofs[AW-1:0] = h_addr;
   end

   assign is_data = (ofs == OFS_DATA);
   assign data_rd = h_sel && !h_wr && is_data;

   always_comb begin
      if (is_data && srst_active) h_ready = 1'b0;
      else if (data_rd)           h_ready = seq_rdone;
      else                        h_ready = seq_idle;
   end

   assign accept   = h_sel && h_ready;
   assign start_wr = accept && h_wr && is_data && (mode.cle || mode.ale || mode.wen);
   assign start_rd = data_rd && seq_idle && !srst_active;
   assign reg_wr   = accept && h_wr && !is_data;

   nfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fl_rb_n),
      .q     (rb_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rb_prev_q <= 1'b1;
      else        rb_prev_q <= rb_s;
   end

   nfc_regs #(
      .DW         (DW),
      .RST_CYCLES (RST_CYCLES),
      .DEF_HOLD   (DEF_HOLD),
      .DEF_SPW    (DEF_SPW)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr),
      .ofs         (ofs),
      .wbyte       (h_wdata[7:0]),
      .busy        (!rb_s),
      .ready_rise  (rb_s && !rb_prev_q),
      .mode        (mode),
      .spw         (spw),
      .hold        (hold),
      .srst_active (srst_active),
      .irq         (irq),
      .rd_data     (reg_rdata)
   );

   nfc_strobe_seq #(.TW(4)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (srst_active),
      .start_wr (start_wr),
      .start_rd (start_rd),
      .wbyte    (h_wdata[7:0]),
      .spw      (spw),
      .hold     (hold),
      .dq_in    (fl_dq_in),
      .we_n     (fl_we_n),
      .re_n     (fl_re_n),
      .dq_o     (fl_dq_o),
      .dq_oe    (fl_dq_oe),
      .idle     (seq_idle),
      .rdone    (seq_rdone),
      .rbyte    (rbyte)
   );

   always_comb begin
      if (data_rd) begin
         h_rdata = '0;
         h_rdata[7:0] = rbyte;
      end else begin
         h_rdata = reg_rdata;
      end
   end

   assign fl_cle = mode.cle;
   assign fl_ale = mode.ale;

   generate
      if (NCS == 1) begin : g_ce_single
         assign fl_ce_n[0] = !mode.ce;
      end else begin : g_ce_multi
         for (genvar i = 0; i < NCS; i++) begin : g_ce
            assign fl_ce_n[i] = !(mode.ce && (mode.cs == 2'(i)));
         end
      end
   endgenerate
endmodule

// File: rtl/nfbus_ctrl_chk.sv
module nfbus_ctrl_chk #(
   parameter int NCS = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           h_ready,
   input logic           fl_we_n,
   input logic           fl_re_n,
   input logic           fl_dq_oe,
   input logic [7:0]     fl_dq_o,
   input logic [NCS-1:0] fl_ce_n
);
   a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_re_n));

   a_r3_bus_driven_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> fl_dq_oe);

   a_r3_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_dq_o));

   a_r6_bus_released_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_re_n |-> !fl_dq_oe);

   a_r2_single_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~fl_ce_n) <= 1);

   a_r5_hold_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> fl_dq_oe);

   a_r5_stall_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n || !fl_re_n) |-> !h_ready);
endmodule

bind nfbus_ctrl nfbus_ctrl_chk #(.NCS(NCS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .h_ready  (h_ready),
   .fl_we_n  (fl_we_n),
   .fl_re_n  (fl_re_n),
   .fl_dq_oe (fl_dq_oe),
   .fl_dq_o  (fl_dq_o),
   .fl_ce_n  (fl_ce_n)
);

// File: tb/sim_nfbus_ctrl.sv
module sim_nfbus_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_sel = 1'b0;
   logic        h_wr = 1'b0;
   logic [4:0]  h_addr = '0;
   logic [31:0] h_wdata = '0;
   logic [31:0] h_rdata;
   logic        h_ready;
   logic        irq;
   logic        fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
   logic [3:0]  fl_ce_n;
   logic [7:0]  fl_dq_o;
   logic [7:0]  fl_dq_in = '0;
   logic        fl_rb_n = 1'b1;

   always #4 clk = ~clk;

   nfbus_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready), .irq(irq),
      .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
      .fl_re_n(fl_re_n), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
      .fl_dq_in(fl_dq_in), .fl_rb_n(fl_rb_n)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      string       tag;
      logic [31:0] exp;
   } sb_item_t;
   sb_item_t exp_q[$];

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares every completed read with the queued value
   always @(posedge clk) begin
      if (rst_n && h_sel && !h_wr && h_ready) begin
         if (exp_q.size() == 0) begin
            check("SB unexpected read", 32'd1, 32'd0);
         end else begin
            sb_item_t it;
            it = exp_q.pop_front();
            check(it.tag, h_rdata, it.exp);
         end
      end
   end

   // bus monitor and flash read model
   int we_run = 0, we_width = 0, hold_run = 0, hold_meas = 0;
   int re_run = 0, re_width = 0, strobes = 0, rc = 0;
   logic [7:0] we_byte = '0;
   logic [7:0] rd_base = '0;
   always @(negedge clk) begin
      if (!fl_we_n) begin
         we_run++;
         we_byte = fl_dq_o;
      end else if (we_run != 0) begin
         we_width = we_run;
         we_run = 0;
         strobes++;
      end
      if (fl_we_n && fl_dq_oe) hold_run++;
      else if (!fl_dq_oe && hold_run != 0) begin
         hold_meas = hold_run;
         hold_run = 0;
      end
      if (!fl_re_n) begin
         re_run++;
         rc++;
         fl_dq_in = rd_base + 8'(rc);
      end else begin
         if (re_run != 0) re_width = re_run;
         re_run = 0;
         rc = 0;
      end
   end

   task automatic xfer(input bit wr, input logic [4:0] addr, input logic [31:0] data);
      @(negedge clk);
      h_sel = 1'b1; h_wr = wr; h_addr = addr; h_wdata = data;
      #1;
      while (!h_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      h_sel = 1'b0;
   endtask

   task automatic rd_expect(input logic [4:0] addr, input logic [31:0] exp, input string tag);
      sb_item_t it;
      it.tag = tag;
      it.exp = exp;
      exp_q.push_back(it);
      xfer(1'b0, addr, 32'h0);
   endtask

   // write to the data register, then measure the busy window
   task automatic data_wr(input logic [31:0] data, input int exp_w, input int exp_h,
                          input logic [7:0] exp_b, input string tag);
      int n = 0;
      int s0 = strobes;
      xfer(1'b1, 5'h00, data);
      @(negedge clk);
      #1;
      while (!h_ready) begin
         n++;
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      @(negedge clk);
      check({tag, " busy cycles"}, n, exp_w + exp_h);
      if (exp_w > 0) begin
         check({tag, " strobe width"}, we_width, exp_w);
         check({tag, " hold cycles"}, hold_meas, exp_h);
         check({tag, " bus byte"}, {24'h0, we_byte}, {24'h0, exp_b});
         check({tag, " strobe count"}, strobes - s0, 1);
      end else begin
         check({tag, " no strobe"}, strobes - s0, 0);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      // R1: reset state
      check("R1 pins in reset", {fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe, h_ready},
            {4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
      rst_n = 1'b1;
      wait_cyc(2);
      check("R1 pins after reset", {fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe, h_ready},
            {4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});

      // R10 / R11: defaults and map
      rd_expect(5'h14, 32'h13, "R10 timing default");
      rd_expect(5'h1C, 32'h0,  "R11 unmapped read");
      xfer(1'b1, 5'h14, 32'hFFFF_FF32);
      rd_expect(5'h14, 32'h32, "R10 timing readback");

      // R2: mode pins
      xfer(1'b1, 5'h04, 32'h89);
      wait_cyc(1);
      check("R2 ce off, cle on", {fl_ce_n, fl_cle, fl_ale}, {4'hF, 1'b1, 1'b0});
      rd_expect(5'h04, 32'h89, "R2 mode readback");
      xfer(1'b1, 5'h04, 32'h9A);
      wait_cyc(1);
      check("R2 ce2 selected, ale on", {fl_ce_n, fl_cle, fl_ale}, {4'b1011, 1'b0, 1'b1});
      xfer(1'b1, 5'h04, 32'hFF);
      wait_cyc(1);
      check("R2 ce3 selected", {fl_ce_n, fl_cle, fl_ale}, {4'b0111, 1'b1, 1'b1});
      rd_expect(5'h04, 32'h9F, "R2 reserved bits read 0");

      // R3 / R5: write strobes
      xfer(1'b1, 5'h04, 32'h11);
      data_wr(32'h0000_01A5, 3, 3, 8'hA5, "R3 cmd write spw2 hold3");
      xfer(1'b1, 5'h14, 32'h05);
      xfer(1'b1, 5'h04, 32'h12);
      data_wr(32'hFFFF_FF3C, 6, 1, 8'h3C, "R5 addr write hold0 min1");
      xfer(1'b1, 5'h14, 32'hF0);
      xfer(1'b1, 5'h04, 32'h90);
      data_wr(32'h0000_0077, 1, 15, 8'h77, "R5 data write spw0 hold15");

      // R4: nothing latched -> no strobe, no stall
      xfer(1'b1, 5'h04, 32'h10);
      data_wr(32'h0000_00EE, 0, 0, 8'h00, "R4 ignored write");

      // R6: read strobes
      xfer(1'b1, 5'h14, 32'h21);
      rd_base = 8'h40;
      rd_expect(5'h00, 32'h42, "R6 read spw1 data");
      wait_cyc(1);
      check("R6 read strobe width spw1", re_width, 2);
      xfer(1'b1, 5'h14, 32'h04);
      rd_base = 8'h70;
      rd_expect(5'h00, 32'h75, "R6 read spw4 data");
      wait_cyc(1);
      check("R6 read strobe width spw4", re_width, 5);

      // R7 / R8: busy status and interrupt
      xfer(1'b1, 5'h10, 32'h1);
      fl_rb_n = 1'b0;
      wait_cyc(4);
      rd_expect(5'h08, 32'h80, "R7 busy bit set");
      check("R8 no irq while busy", irq, 1'b0);
      fl_rb_n = 1'b1;
      wait_cyc(4);
      rd_expect(5'h08, 32'h00, "R7 busy bit clear");
      rd_expect(5'h0C, 32'h01, "R8 ready edge latched");
      check("R8 irq raised", irq, 1'b1);
      xfer(1'b1, 5'h0C, 32'h1);
      rd_expect(5'h0C, 32'h00, "R8 isr cleared");
      check("R8 irq dropped", irq, 1'b0);
      xfer(1'b1, 5'h10, 32'h0);
      fl_rb_n = 1'b0;
      wait_cyc(4);
      fl_rb_n = 1'b1;
      wait_cyc(4);
      rd_expect(5'h0C, 32'h01, "R8 masked edge latched");
      check("R8 masked irq low", irq, 1'b0);

      // R9: soft reset
      xfer(1'b1, 5'h10, 32'h1);
      xfer(1'b1, 5'h04, 32'h13);
      xfer(1'b1, 5'h18, 32'h1);
      rd_expect(5'h18, 32'h1, "R9 reset bit reads 1");
      wait_cyc(12);
      rd_expect(5'h18, 32'h0, "R9 reset bit self clears");
      rd_expect(5'h04, 32'h0, "R9 mode default");
      rd_expect(5'h14, 32'h13, "R9 timing default");
      rd_expect(5'h10, 32'h0, "R9 mask default");
      rd_expect(5'h0C, 32'h0, "R9 isr default");
      check("R9 ce released", fl_ce_n, 4'hF);

      wait_cyc(2);
      check("SB queue drained", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule